// File: doc/BRIEF.md
# Chain-Addressed Serial Control Slave

This block is the control-port front end of one device in a string of identical devices that share a single chip-select serial bus. Each device leaves reset listening on a common power-up chip address. It holds its chain-enable output low, and that output keeps the next device in the string in reset. The host writes a fresh individual address into the device, together with an enable bit. From then on the device answers only at that new address, and its chain-enable output rises to release the next device. The host repeats this down the string until every device has a unique address.

Each bus cycle begins when chip-select goes low. The first byte carries a 7-bit chip address in bits 7..1 and a direction bit in bit 0 (0 = write, 1 = read). That address is compared with the individual address and with two group addresses. A device that is not addressed stays idle until chip-select rises again. The second byte is a register pointer. The bytes after it are data, and the pointer advances by one after each data byte. CS, SCLK and data-in are brought into the system clock domain through two-flop synchronisers. Data-in is sampled on rising SCLK edges, MSB first.

The register file holds NREG bytes. Pointer 0 is the individual register, with the address in bits 7..1 and the chain-enable bit in bit 0. Pointer 1 is group 1 and pointer 2 is group 2, each with its address in bits 7..1. Pointers 3 to NREG-1 are general control bytes that reset to 0. All register bytes are presented on `ctl_q`, with byte k at bits [8k+7:8k].

Top module: `chain_ctl_slave`

## Requirements
- R1: While `rst` is high, `en_out` is low in that same cycle. After reset, register 0 holds {DEF_ADDR, 0}, register 1 holds {G1_ADDR, 0}, register 2 holds {G2_ADDR, 0}, and all other registers hold 0.
- R2: `en_out` follows bit 0 of register 0. It stays low until a write sets that bit to 1, and it drops again when a write clears the bit.
- R3: After reset, a write cycle whose first byte is {DEF_ADDR, 0} is accepted.
- R4: One write to pointer 0 applies the new address and the enable bit together. After that, cycles sent to the old default address are ignored and cycles sent to the new address are accepted.
- R5: A write whose address matches group 1 or group 2 is accepted. A read whose address matches only a group address is refused, and `sdo` stays 0 for that cycle.
- R6: When the first byte matches none of the three addresses, every later byte of that cycle is ignored, even one that looks like a valid header. Nothing is written and `sdo` stays 0 until chip-select rises.
- R7: Within one cycle, the pointer advances by one after each data byte, for both writes and reads.
- R8: A read (bit 0 = 1) that matches the individual address drives the addressed register onto `sdo`, MSB first. Each bit is valid before the SCLK rising edge that ends its bit slot.
- R9: A write to a pointer at or above NREG changes no register. A read at such a pointer returns 0.
- R10: The chip address is 7 bits wide, so 128 distinct values are possible. Across all 128 values, exactly the individual, group 1 and group 2 addresses accept writes, and only the individual address accepts reads.
- R11: When chip-select rises partway through a byte, the partial byte is discarded. A partial data byte writes nothing, and the next cycle decodes its first byte as a fresh address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high device reset |
| cs_n | input | 1 | Active-low chip-select, asynchronous to `clk` |
| sclk | input | 1 | Serial clock, idles low, asynchronous to `clk` |
| sdi | input | 1 | Serial data in, sampled on SCLK rising edges |
| en_out | output | 1 | Chain-enable to the next device's reset |
| sdo | output | 1 | Serial read data; 0 when not reading |
| ctl_q | output | NREG*8 | All register bytes, byte k at [8k+7:8k] |

## Verification
The bench sweeps every one of the 128 chip addresses, once as a write and once as a read. A comparator that ignored a group register, compared the wrong bit field, or let a group address read would show up as a stray register change or a non-zero `sdo`. It sends a valid-looking header after an unmatched first byte. A design that re-decoded the header instead of staying idle until chip-select rises would write a register. It also cuts cycles off mid-byte. A design that kept the leftover bit count or the partial byte would misread the next header or commit a half-received data byte. The enable bit is cleared and set again, and reset is applied while the bit is set, so an output that was not tied to the register bit and to reset would be caught.

// File: rtl/chain_ctl_pkg.sv
package chain_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int CHIP_W = 7;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_PTR  = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    typedef struct packed {
        logic [CHIP_W-1:0] chip;
        logic              rd;
    } head_t;

    function automatic logic [BYTE_W-1:0] reg_init(
        input int              idx,
        input logic [CHIP_W-1:0] def_a,
        input logic [CHIP_W-1:0] g1_a,
        input logic [CHIP_W-1:0] g2_a
    );
        case (idx)
            0:       return {def_a, 1'b0};
            1:       return {g1_a, 1'b0};
            2:       return {g2_a, 1'b0};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/chain_sync.sv
module chain_sync #(
    parameter int              W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= din[i];
                sync_q <= meta_q;
            end
        end
        assign dout[i] = sync_q;
    end
endmodule

// File: rtl/chain_regs.sv
module chain_regs
    import chain_ctl_pkg::*;
#(
    parameter int                NREG     = 8,
    parameter logic [CHIP_W-1:0] DEF_ADDR = 7'h40,
    parameter logic [CHIP_W-1:0] G1_ADDR  = 7'h70,
    parameter logic [CHIP_W-1:0] G2_ADDR  = 7'h71
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [BYTE_W-1:0]      wr_ptr,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [BYTE_W-1:0]      rd_ptr,
    output logic [BYTE_W-1:0]      rd_byte,
    output logic [CHIP_W-1:0]      ind_addr,
    output logic [CHIP_W-1:0]      g1_addr,
    output logic [CHIP_W-1:0]      g2_addr,
    output logic                   en_bit,
    output logic [NREG*BYTE_W-1:0] regs_flat
);
    localparam logic [BYTE_W:0] NREG_W = (BYTE_W+1)'(NREG);

    logic [BYTE_W-1:0] mem [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [BYTE_W-1:0] INIT = reg_init(i, DEF_ADDR, G1_ADDR, G2_ADDR);
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= INIT;
            else if (wr_en && wr_ptr == BYTE_W'(i))
                mem[i] <= wr_data;
        end
        assign regs_flat[i*BYTE_W +: BYTE_W] = mem[i];
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_ptr == BYTE_W'(i))
                rd_byte = mem[i];
    end

    assign ind_addr = mem[0][BYTE_W-1:1];
    assign en_bit   = mem[0][0];
    assign g1_addr  = mem[1][BYTE_W-1:1];
    assign g2_addr  = mem[2][BYTE_W-1:1];

    // R2: the enable bit only rises through a write of 1 to pointer 0
    assert_en_rise_by_write_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(en_bit) |-> $past(wr_en && wr_ptr == '0 && wr_data[0]));

    // R9: out-of-range writes leave the whole file untouched
    assert_oob_write_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && {1'b0, wr_ptr} >= NREG_W) |=> $stable(regs_flat));

endmodule

// File: rtl/chain_frame.sv
module chain_frame
    import chain_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sdi,
    input  logic [CHIP_W-1:0] ind_addr,
    input  logic [CHIP_W-1:0] g1_addr,
    input  logic [CHIP_W-1:0] g2_addr,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_ptr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_ptr,
    output logic              sdo
);
    phase_e            ph;
    logic [2:0]        bitcnt;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic              rd_mode;

    logic [BYTE_W-1:0] cur_byte;
    head_t             hd;
    logic              byte_done, ind_hit, grp_hit, accept;

    assign cur_byte  = {shreg, sdi};
    assign hd        = cur_byte;
    assign byte_done = cs_act && sclk_rise && bitcnt == 3'd7;
    assign ind_hit   = hd.chip == ind_addr;
    assign grp_hit   = hd.chip == g1_addr || hd.chip == g2_addr;
    assign accept    = hd.rd ? ind_hit : (ind_hit || grp_hit);

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            ph      <= PH_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            rd_mode <= 1'b0;
            if (rst) ptr <= '0;
        end else if (sclk_rise) begin
            bitcnt <= bitcnt + 3'd1;
            shreg  <= cur_byte[BYTE_W-2:0];
            if (bitcnt == 3'd7) begin
                unique case (ph)
                    PH_ADDR: begin
                        if (accept) begin
                            ph      <= PH_PTR;
                            rd_mode <= hd.rd;
                        end else begin
                            ph <= PH_SKIP;
                        end
                    end
                    PH_PTR: begin
                        ptr <= cur_byte;
                        ph  <= PH_DATA;
                    end
                    PH_DATA: ptr <= ptr + 8'd1;
                    default: ph <= PH_SKIP;
                endcase
            end
        end
    end

    assign wr_en   = byte_done && ph == PH_DATA && !rd_mode;
    assign wr_ptr  = ptr;
    assign wr_data = cur_byte;
    assign rd_ptr  = ptr;
    assign sdo     = (ph == PH_DATA && rd_mode) ? rd_byte[3'd7 - bitcnt] : 1'b0;

    // R6: an unaddressed cycle never leaves the skip phase while selected
    assert_skip_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SKIP && cs_act) |=> ph == PH_SKIP);

    // R5: a read header that misses the individual address is refused
    assert_read_needs_ind_R5: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ADDR && byte_done && hd.rd && !ind_hit) |=> ph == PH_SKIP);

    // R7: pointer advances by one per completed data byte
    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DATA && byte_done) |=> ptr == $past(ptr) + 8'd1);

    // R11: deselect clears the bit position
    assert_deselect_clears_R11: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (bitcnt == 3'd0 && ph == PH_ADDR));

endmodule

// File: rtl/chain_ctl_slave.sv
module chain_ctl_slave
    import chain_ctl_pkg::*;
#(
    parameter int                NREG     = 8,
    parameter logic [CHIP_W-1:0] DEF_ADDR = 7'h40,
    parameter logic [CHIP_W-1:0] G1_ADDR  = 7'h70,
    parameter logic [CHIP_W-1:0] G2_ADDR  = 7'h71
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   sclk,
    input  logic                   sdi,
    output logic                   en_out,
    output logic                   sdo,
    output logic [NREG*BYTE_W-1:0] ctl_q
);
    logic [2:0]        pins_s;
    logic              sclk_d, cs_act, sclk_rise;
    logic              wr_en, en_bit;
    logic [BYTE_W-1:0] wr_ptr, wr_data, rd_ptr, rd_byte;
    logic [CHIP_W-1:0] ind_addr, g1_addr, g2_addr;

    chain_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cs_n, sclk, sdi}),
        .dout (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= pins_s[1];
    end

    assign cs_act    = !pins_s[2];
    assign sclk_rise = pins_s[1] && !sclk_d;

    chain_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sdi       (pins_s[0]),
        .ind_addr  (ind_addr),
        .g1_addr   (g1_addr),
        .g2_addr   (g2_addr),
        .rd_byte   (rd_byte),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .rd_ptr    (rd_ptr),
        .sdo       (sdo)
    );

    chain_regs #(
        .NREG(NREG), .DEF_ADDR(DEF_ADDR), .G1_ADDR(G1_ADDR), .G2_ADDR(G2_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .rd_ptr    (rd_ptr),
        .rd_byte   (rd_byte),
        .ind_addr  (ind_addr),
        .g1_addr   (g1_addr),
        .g2_addr   (g2_addr),
        .en_bit    (en_bit),
        .regs_flat (ctl_q)
    );

    assign en_out = en_bit && !rst;

endmodule

// File: tb/chain_ctl_slave_tb.sv
module chain_ctl_slave_tb;
    localparam int         NREG = 8;
    localparam logic [6:0] DEFA = 7'h40;
    localparam logic [6:0] G1A  = 7'h70;
    localparam logic [6:0] G2A  = 7'h71;
    localparam int         HALF = 4;

    logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic en_out, sdo;
    logic [NREG*8-1:0] ctl_q;

    int errors = 0, checks = 0;
    bit done = 1'b0;
    logic [7:0] mdl [NREG];

    always #4 clk = ~clk;

    chain_ctl_slave #(.NREG(NREG), .DEF_ADDR(DEFA), .G1_ADDR(G1A), .G2_ADDR(G2A)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .en_out(en_out), .sdo(sdo), .ctl_q(ctl_q)
    );

    task automatic chk(input string tag, input logic [NREG*8-1:0] act, input logic [NREG*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mdl_reset();
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        mdl[0] = {DEFA, 1'b0};
        mdl[1] = {G1A, 1'b0};
        mdl[2] = {G2A, 1'b0};
    endtask

    task automatic check_all(input string tag);
        logic [NREG*8-1:0] e;
        for (int i = 0; i < NREG; i++) e[i*8 +: 8] = mdl[i];
        chk(tag, ctl_q, e);
        chk(tag, {{(NREG*8-1){1'b0}}, en_out}, {{(NREG*8-1){1'b0}}, mdl[0][0]});
    endtask

    task automatic sbit(input logic b, output logic so);
        sdi = b;
        repeat (HALF) @(negedge clk);
        so = sdo;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) sbit(b[i], r[i]);
    endtask

    task automatic cs_on();
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic hit_wr(input logic [6:0] a);
        return a == mdl[0][7:1] || a == mdl[1][7:1] || a == mdl[2][7:1];
    endfunction

    task automatic wr_frame(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d0, input int n);
        logic [7:0] r;
        logic hit;
        hit = hit_wr(a);
        cs_on();
        sbyte({a, 1'b0}, r);
        sbyte(p, r);
        for (int k = 0; k < n; k++) begin
            sbyte(d0 + 8'(k * 8'h11), r);
            if (hit && int'(p) + k < NREG) mdl[int'(p) + k] = d0 + 8'(k * 8'h11);
        end
        cs_off();
    endtask

    task automatic rd_frame(input string tag, input logic [6:0] a, input logic [7:0] p, input int n);
        logic [7:0] r, e;
        logic hit;
        hit = (a == mdl[0][7:1]);
        cs_on();
        sbyte({a, 1'b1}, r);
        sbyte(p, r);
        for (int k = 0; k < n; k++) begin
            sbyte(8'h00, r);
            e = (hit && int'(p) + k < NREG) ? mdl[int'(p) + k] : 8'h00;
            chk(tag, {{(NREG*8-8){1'b0}}, r}, {{(NREG*8-8){1'b0}}, e});
        end
        cs_off();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic b;
        mdl_reset();
        repeat (3) @(negedge clk);
        chk("R1 en_out low in reset", {{(NREG*8-1){1'b0}}, en_out}, '0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1 reset values");

        wr_frame(DEFA, 8'd3, 8'hA5, 1);
        check_all("R3 default address write");

        wr_frame(G1A, 8'd4, 8'h3C, 1);
        check_all("R5 group1 write");
        wr_frame(G2A, 8'd5, 8'hC3, 1);
        check_all("R5 group2 write");
        rd_frame("R5 group read refused", G1A, 8'd3, 1);
        rd_frame("R8 R7 individual read burst", DEFA, 8'd3, 3);

        wr_frame(DEFA, 8'd0, {7'h15, 1'b1}, 1);
        check_all("R4 address and enable in one write");
        wr_frame(DEFA, 8'd6, 8'h99, 1);
        check_all("R4 old default ignored");
        wr_frame(7'h15, 8'd6, 8'h66, 1);
        check_all("R4 new address accepted");

        wr_frame(7'h15, 8'd3, 8'h10, 5);
        check_all("R7 write burst");
        wr_frame(7'h15, 8'd6, 8'h81, 4);
        check_all("R9 write past end");
        rd_frame("R9 read past end", 7'h15, 8'd7, 3);

        cs_on();
        sbyte({7'h22, 1'b0}, r);
        sbyte({7'h15, 1'b0}, r);
        sbyte(8'd3, r);
        sbyte(8'hEE, r);
        cs_off();
        check_all("R6 unmatched cycle ignored");
        cs_on();
        sbyte({7'h22, 1'b1}, r);
        sbyte({7'h15, 1'b1}, r);
        sbyte(8'd3, r);
        sbyte(8'h00, r);
        cs_off();
        chk("R6 no read data when unmatched", {{(NREG*8-8){1'b0}}, r}, '0);

        cs_on();
        for (int i = 0; i < 4; i++) sbit(1'b1, b);
        cs_off();
        wr_frame(7'h15, 8'd4, 8'h5D, 1);
        check_all("R11 abort in header then fresh cycle");
        cs_on();
        sbyte({7'h15, 1'b0}, r);
        sbyte(8'd4, r);
        for (int i = 0; i < 5; i++) sbit(1'b0, b);
        cs_off();
        check_all("R11 partial data byte dropped");

        wr_frame(7'h15, 8'd0, {7'h15, 1'b0}, 1);
        check_all("R2 enable cleared");
        wr_frame(7'h15, 8'd0, {7'h15, 1'b1}, 1);
        check_all("R2 enable set again");

        @(negedge clk) rst = 1'b1;
        #1;
        chk("R1 en_out drops with reset", {{(NREG*8-1){1'b0}}, en_out}, '0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl_reset();
        repeat (2) @(negedge clk);
        check_all("R1 values after second reset");

        wr_frame(DEFA, 8'd0, {7'h15, 1'b1}, 1);
        for (int a = 0; a < 128; a++) begin
            wr_frame(7'(a), 8'd3, 8'(a) ^ 8'h5A, 1);
            check_all("R10 write address sweep");
        end
        for (int a = 0; a < 128; a++)
            rd_frame("R10 read address sweep", 7'(a), 8'd3, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule